// File: doc/BRIEF.md
# Video Memory Constant-Fill Engine

This block owns the shared write address of a video memory data port and uses it in two ways. An ordinary data-port write whose command selects a video-memory store puts the word into memory in the same cycle, then advances the address by the auto-increment step. A data-port write whose command selects fill mode stores nothing. It captures the word as a fill pattern and starts the engine.

While the engine is busy and enabled, it stores the captured pattern at the current address on every clock. The address advances by the step after each store and a length counter counts down. The engine stops when the counter reaches zero. A busy bit is folded into a status word. The data port reports not-ready for the whole fill, so a CPU waits instead of racing the engine for the address. On odd byte addresses the two bytes of every stored word are exchanged, both for ordinary writes and for fill writes.

Top module: `vram_fill_engine`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises: active_o=0, dp_ready_o=1, vram_we_o=0, addr_o=0.
- R2: A pulse on addr_ld_i while dp_ready_o=1 sets addr_o to addr_i on the next clock.
- R3: A data-port write accepted with cmd_i[5:4]=2'b10 stores nothing in that cycle. It sets active_o on the next clock and captures dp_data_i as the fill pattern.
- R4: While active, a store happens only in cycles where dma_en_i=1 and dma_mode_i=2'd2. In any other cycle vram_we_o stays 0, addr_o holds and active_o stays set.
- R5: Every store drives vram_addr_o=addr_o[15:1]. vram_wdata_o is the word with its two bytes exchanged when addr_o[0]=1, and the word unchanged when addr_o[0]=0.
- R6: After each store addr_o increases by incr_i, modulo 2^16. A fill started with length L>0 makes exactly L stores, and active_o clears on the clock of the last store.
- R7: A fill started with len_i=0 makes 65536 stores.
- R8: status_o equals 16'h3400 with bit 1 set to active_o.
- R9: dp_ready_o is low exactly while active_o is high. Data-port writes and address loads offered in that time are ignored.
- R10: An accepted data-port write with cmd_i[5:4]!=2'b10 and cmd_i[3:0]=4'h1 stores dp_data_i in the same cycle and advances addr_o by incr_i.
- R11: An accepted data-port write with cmd_i[5:4]!=2'b10 and cmd_i[3:0]!=4'h1 causes no store and leaves addr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | DMA enable from the mode register |
| dma_mode_i | input | 2 | DMA mode field; 2 selects fill |
| len_i | input | 16 | Fill length in words; 0 means 65536 |
| incr_i | input | 8 | Address auto-increment step |
| addr_ld_i | input | 1 | Load pulse for the address register |
| addr_i | input | 16 | Byte address to load |
| cmd_i | input | 6 | Current command code |
| dp_wr_i | input | 1 | Data-port write strobe |
| dp_data_i | input | 16 | Data-port write word |
| dp_ready_o | output | 1 | Data port can accept a write or an address load |
| vram_we_o | output | 1 | Video memory write enable |
| vram_addr_o | output | 15 | Video memory word address |
| vram_wdata_o | output | 16 | Video memory write word |
| addr_o | output | 16 | Current byte address |
| active_o | output | 1 | Fill in progress |
| status_o | output | 16 | Status word with the busy bit |

## Verification
The bench builds the block with its default widths: a 16-bit address, a 16-bit word, a 16-bit length and an 8-bit step. With these defaults, the 65536-word fill that a zero length implies finishes well inside the run. The address wrap past 16'hFFFF and the byte exchange on odd addresses can both be reached with a single load. A table of ordinary writes covers the store and no-store command codes. Directed runs cover a fill that is held back by the enable and mode inputs and interrupted by writes and loads that must be ignored.

// File: rtl/vfe_pkg.sv
package vfe_pkg;
  localparam int CMD_W = 6;
  localparam logic [1:0] FILL_SEL = 2'b10;
  localparam logic [3:0] VRAM_WR_CODE = 4'h1;
  localparam logic [1:0] FILL_MODE = 2'd2;
  localparam logic [15:0] STATUS_BASE = 16'h3400;

  typedef enum logic [1:0] {
    CK_NONE    = 2'd0,
    CK_VRAM_WR = 2'd1,
    CK_FILL    = 2'd2
  } cmd_kind_e;

  function automatic cmd_kind_e decode_cmd(input logic [CMD_W-1:0] cmd);
    if (cmd[5:4] == FILL_SEL) return CK_FILL;
    if (cmd[3:0] == VRAM_WR_CODE) return CK_VRAM_WR;
    return CK_NONE;
  endfunction
endpackage

// File: rtl/vfe_addr_reg.sv
module vfe_addr_reg #(
  parameter int ADDR_W = 16,
  parameter int INC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  input  logic              step_i,
  input  logic [INC_W-1:0]  inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (ld_i)   addr_q <= ld_val_i;
    else if (step_i) addr_q <= addr_q + ADDR_W'(inc_i);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/vfe_len_ctr.sv
module vfe_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam int CNT_W = LEN_W + 1;
  logic [CNT_W-1:0] cnt_q;

  // zero length maps to 2**LEN_W via the extra top bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= {(len_i == '0), len_i};
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/vfe_wport.sv
module vfe_wport #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter bit SWAP_ODD = 1'b1
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [ADDR_W-2:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int HALF = DATA_W / 2;

  assign we_o    = en_i;
  assign waddr_o = addr_i[ADDR_W-1:1];

  generate
    if (SWAP_ODD) begin : g_swap
      assign wdata_o = addr_i[0] ? {data_i[HALF-1:0], data_i[DATA_W-1:HALF]} : data_i;
    end else begin : g_plain
      assign wdata_o = data_i;
    end
  endgenerate
endmodule

// File: rtl/vram_fill_engine.sv
module vram_fill_engine #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       dma_en_i,
  input  logic [1:0]                 dma_mode_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic [INC_W-1:0]           incr_i,
  input  logic                       addr_ld_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [vfe_pkg::CMD_W-1:0]  cmd_i,
  input  logic                       dp_wr_i,
  input  logic [DATA_W-1:0]          dp_data_i,
  output logic                       dp_ready_o,
  output logic                       vram_we_o,
  output logic [ADDR_W-2:0]          vram_addr_o,
  output logic [DATA_W-1:0]          vram_wdata_o,
  output logic [ADDR_W-1:0]          addr_o,
  output logic                       active_o,
  output logic [15:0]                status_o
);
  import vfe_pkg::*;

  logic              active_q;
  logic [DATA_W-1:0] fill_q;
  cmd_kind_e         kind;
  logic              accept, arm, norm_wr, run, last, step;
  logic [DATA_W-1:0] wsrc;

  assign kind    = decode_cmd(cmd_i);
  assign accept  = dp_wr_i & ~active_q;
  assign arm     = accept & (kind == CK_FILL);
  assign norm_wr = accept & (kind == CK_VRAM_WR);
  assign run     = active_q & dma_en_i & (dma_mode_i == FILL_MODE);
  assign step    = run | norm_wr;
  assign wsrc    = run ? fill_q : dp_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      fill_q   <= '0;
    end else if (arm) begin
      active_q <= 1'b1;
      fill_q   <= dp_data_i;
    end else if (run && last) begin
      active_q <= 1'b0;
    end
  end

  vfe_addr_reg #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (addr_ld_i & ~active_q),
    .ld_val_i (addr_i),
    .step_i   (step),
    .inc_i    (incr_i),
    .addr_o   (addr_o)
  );

  vfe_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (arm),
    .len_i  (len_i),
    .dec_i  (run),
    .last_o (last)
  );

  vfe_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SWAP_ODD(1'b1)) u_wport (
    .en_i    (step),
    .addr_i  (addr_o),
    .data_i  (wsrc),
    .we_o    (vram_we_o),
    .waddr_o (vram_addr_o),
    .wdata_o (vram_wdata_o)
  );

  assign dp_ready_o = ~active_q;
  assign active_o   = active_q;
  assign status_o   = STATUS_BASE | {14'b0, active_q, 1'b0};
endmodule

// File: rtl/vfe_checker.sv
module vfe_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      dma_en_i,
  input logic [1:0]                dma_mode_i,
  input logic [LEN_W-1:0]          len_i,
  input logic [INC_W-1:0]          incr_i,
  input logic                      addr_ld_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [vfe_pkg::CMD_W-1:0] cmd_i,
  input logic                      dp_wr_i,
  input logic [DATA_W-1:0]         dp_data_i,
  input logic                      dp_ready_o,
  input logic                      vram_we_o,
  input logic [ADDR_W-2:0]         vram_addr_o,
  input logic [DATA_W-1:0]         vram_wdata_o,
  input logic [ADDR_W-1:0]         addr_o,
  input logic                      active_o,
  input logic [15:0]               status_o
);
  logic unused_ok;
  assign unused_ok = ^{len_i, addr_i, dp_data_i, vram_wdata_o, status_o};

  a_r3_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_ready_o && dp_wr_i && cmd_i[5:4] == 2'b10) |=> active_o);

  a_r3_no_store_on_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_ready_o && dp_wr_i && cmd_i[5:4] == 2'b10) |-> !vram_we_o);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !(dma_en_i && dma_mode_i == 2'd2)) |=> ($stable(addr_o) && active_o));

  a_r5_word_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o |-> (vram_addr_o == addr_o[ADDR_W-1:1]));

  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_we_o && active_o) |=> (addr_o == $past(addr_o) + ADDR_W'($past(incr_i))));

  a_r9_busy_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !dp_ready_o);

  a_r11_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_ready_o && dp_wr_i && !addr_ld_i && cmd_i[5:4] != 2'b10 && cmd_i[3:0] != 4'h1)
      |=> $stable(addr_o));
endmodule

bind vram_fill_engine vfe_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .INC_W(INC_W)
) u_chk (.*);

// File: tb/vram_fill_engine_test.sv
module vram_fill_engine_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dma_en_i = 1'b0;
  logic [1:0]  dma_mode_i = 2'd0;
  logic [15:0] len_i = '0;
  logic [7:0]  incr_i = '0;
  logic        addr_ld_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [5:0]  cmd_i = '0;
  logic        dp_wr_i = 1'b0;
  logic [15:0] dp_data_i = '0;
  logic        dp_ready_o, vram_we_o, active_o;
  logic [14:0] vram_addr_o;
  logic [15:0] vram_wdata_o, addr_o, status_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  vram_fill_engine uut (.*);

  typedef struct packed {
    logic [5:0]  cmd;
    logic [15:0] a0;
    logic [7:0]  inc;
    logic [15:0] d;
    logic        we;
    logic [14:0] wa;
    logic [15:0] wd;
    logic [15:0] a1;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{6'h01, 16'h0010, 8'h02, 16'hBEEF, 1'b1, 15'h0008, 16'hBEEF, 16'h0012},
    '{6'h01, 16'h0011, 8'h02, 16'hBEEF, 1'b1, 15'h0008, 16'hEFBE, 16'h0013},
    '{6'h01, 16'hFFFE, 8'h04, 16'h1234, 1'b1, 15'h7FFF, 16'h1234, 16'h0002},
    '{6'h11, 16'h0100, 8'h80, 16'h00FF, 1'b1, 15'h0080, 16'h00FF, 16'h0180},
    '{6'h05, 16'h0040, 8'h02, 16'h5555, 1'b0, 15'h0000, 16'h0000, 16'h0040},
    '{6'h03, 16'h0041, 8'h01, 16'hAAAA, 1'b0, 15'h0000, 16'h0000, 16'h0041}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_addr(input logic [15:0] a);
    @(negedge clk_i);
    addr_ld_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    addr_ld_i = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(input logic [15:0] a, input logic [15:0] d);
    return a[0] ? {d[7:0], d[15:8]} : d;
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] ea;
    int n;
    // R1 reset state
    #1;
    chk("R1 active in reset", active_o, 0);
    chk("R1 ready in reset", dp_ready_o, 1);
    chk("R1 we in reset", vram_we_o, 0);
    chk("R1 addr in reset", addr_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R1 addr after reset", addr_o, 0);
    chk("R1 active after reset", active_o, 0);
    chk("R8 status idle", status_o, 16'h3400);

    // R2 R10 R11 vector table
    for (int i = 0; i < NV; i++) begin
      load_addr(VECS[i].a0);
      #1 chk("R2 address load", addr_o, VECS[i].a0);
      cmd_i = VECS[i].cmd; incr_i = VECS[i].inc; dp_data_i = VECS[i].d; dp_wr_i = 1'b1;
      #1;
      chk(VECS[i].we ? "R10 store enable" : "R11 no store", vram_we_o, VECS[i].we);
      if (VECS[i].we) begin
        chk("R5 word address", vram_addr_o, VECS[i].wa);
        chk("R5 word data", vram_wdata_o, VECS[i].wd);
      end
      @(negedge clk_i);
      dp_wr_i = 1'b0;
      #1 chk(VECS[i].we ? "R10 address step" : "R11 address kept", addr_o, VECS[i].a1);
    end

    // R3 R5 R6 R8 fill of three words from an odd address
    dma_en_i = 1'b1; dma_mode_i = 2'd2;
    load_addr(16'h0101);
    len_i = 16'd3; incr_i = 8'd2; cmd_i = 6'h20; dp_data_i = 16'h12AB; dp_wr_i = 1'b1;
    #1 chk("R3 no store on arm", vram_we_o, 0);
    ea = 16'h0101;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      dp_wr_i = 1'b0; dp_data_i = 16'h0000;
      #1;
      chk("R3 active", active_o, 1);
      chk("R8 status busy", status_o, 16'h3402);
      chk("R6 store each cycle", vram_we_o, 1);
      chk("R5 fill word address", vram_addr_o, {1'b0, ea[15:1]});
      chk("R5 fill data", vram_wdata_o, exp_word(ea, 16'h12AB));
      ea = ea + 16'd2;
    end
    @(negedge clk_i); #1;
    chk("R6 active cleared", active_o, 0);
    chk("R6 final address", addr_o, 16'h0107);
    chk("R6 no extra store", vram_we_o, 0);

    // R4 R9 held fill, ignored writes and loads
    dma_en_i = 1'b0;
    load_addr(16'h0200);
    len_i = 16'd2; incr_i = 8'd1; cmd_i = 6'h20; dp_data_i = 16'hA55A; dp_wr_i = 1'b1;
    @(negedge clk_i);
    dp_data_i = 16'h1111; cmd_i = 6'h01; addr_ld_i = 1'b1; addr_i = 16'h0300;
    #1;
    chk("R9 ready low", dp_ready_o, 0);
    chk("R4 no store disabled", vram_we_o, 0);
    @(negedge clk_i);
    dp_wr_i = 1'b0; addr_ld_i = 1'b0;
    #1;
    chk("R9 write/load ignored", addr_o, 16'h0200);
    chk("R4 still active", active_o, 1);
    dma_en_i = 1'b1; dma_mode_i = 2'd1;
    #1 chk("R4 no store wrong mode", vram_we_o, 0);
    @(negedge clk_i);
    dma_mode_i = 2'd2;
    #1;
    chk("R4 address held", addr_o, 16'h0200);
    chk("R4 store resumes", vram_we_o, 1);
    chk("R5 even no swap", vram_wdata_o, 16'hA55A);
    @(negedge clk_i); #1;
    chk("R5 odd swap", vram_wdata_o, 16'h5AA5);
    chk("R5 same word", vram_addr_o, 15'h0100);
    @(negedge clk_i); #1;
    chk("R6 two stores done", active_o, 0);
    chk("R6 addr after held fill", addr_o, 16'h0202);

    // R7 zero length
    load_addr(16'h0000);
    len_i = 16'd0; incr_i = 8'd1; cmd_i = 6'h20; dp_data_i = 16'h7E7E; dp_wr_i = 1'b1;
    @(negedge clk_i);
    dp_wr_i = 1'b0;
    n = 0;
    while (active_o && n < 70000) begin
      #1 if (vram_we_o) n++;
      @(negedge clk_i);
    end
    chk("R7 zero length count", n, 65536);
    chk("R7 address wrapped", addr_o, 16'h0000);
    chk("R9 ready after fill", dp_ready_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule